// File: doc/BRIEF.md
# Display FIFO Fetch Request Controller

This block decides when to ask memory for more pixel data. It serves two FIFOs: one that holds display (graphics) pixels and one that holds video pixels. The block watches how full each FIFO is and how many entries it has already been granted but has not yet received. When a FIFO has enough room, the block raises a read request for one burst. The request stays up until the memory side acknowledges it. Occupancy is counted in 64-bit entries, so a 32-byte cacheline is 4 entries.

The video FIFO has two trigger modes, chosen by a select bit. In one mode it fetches as soon as one cacheline of space is free. In the other it waits until two cachelines are free and then asks for a 64-byte burst. The display FIFO also has an urgency flag with hysteresis. The flag goes up when the display FIFO drains down to a programmable start level. It comes down once the FIFO has refilled to a programmable end level. Both levels count in groups of four entries. If the levels are programmed badly, the flag is suppressed and a sticky error flag is set.

Top module: `fetch_req_ctrl`

## Requirements
- R1: While enabled with no request pending, if the display FIFO's free space (depth minus occupancy minus in-flight entries) is at least 4 entries, the next cycle shows req_valid_o=1, req_src_o=0 (display) and req_burst_o=0 (32 bytes, 4 entries).
- R2: With vid_64b_i=0 and no display request eligible, a video request (req_src_o=1, req_burst_o=0) is raised when the video FIFO has at least 4 free entries.
- R3: With vid_64b_i=1, a video request is raised only when at least 8 video entries are free, and it carries req_burst_o=1 (64 bytes, 8 entries).
- R4: When both FIFOs are eligible in the same cycle, the display request is issued first.
- R5: A raised request keeps req_valid_o, req_src_o and req_burst_o unchanged until the cycle in which req_ack_i=1. In the following cycle req_valid_o is 0.
- R6: Granted entries count as occupied until one gfx_ret_i/vid_ret_i pulse per entry comes back, so free space is never over-counted.
- R7: With legal levels and enabled, if display occupancy is at or below 4*hp_start_i entries, req_hipri_o is 1 in the next cycle.
- R8: Once high, req_hipri_o stays 1 while occupancy is between the levels. It clears in the cycle after occupancy reaches 4*hp_end_i or more.
- R9: Levels are illegal if either is zero or start is not below end. In that case req_hipri_o is 0 in the next cycle, and cfg_err_o is set (while enabled) and stays set until reset.
- R10: While en_i=0, no new request is raised. A pending request is held until acknowledged. req_hipri_o clears once no request is pending.
- R11: During and right after reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Fetch enable |
| vid_64b_i | input | 1 | Video trigger: 0 = one line free, 1 = two lines free and 64-byte burst |
| hp_start_i | input | LVL_W | High-priority start level, in units of 4 entries |
| hp_end_i | input | LVL_W | High-priority end level, in units of 4 entries |
| gfx_occ_i | input | $clog2(GFX_DEPTH+1) | Display FIFO occupancy, in entries |
| vid_occ_i | input | $clog2(VID_DEPTH+1) | Video FIFO occupancy, in entries |
| gfx_ret_i | input | 1 | One granted display entry written into the FIFO |
| vid_ret_i | input | 1 | One granted video entry written into the FIFO |
| req_ack_i | input | 1 | Memory accepts the pending request |
| req_valid_o | output | 1 | Request pending |
| req_src_o | output | 1 | Requesting FIFO: 0 display, 1 video |
| req_burst_o | output | 1 | Burst size: 0 = 32 bytes, 1 = 64 bytes |
| req_hipri_o | output | 1 | High-priority display request flag |
| cfg_err_o | output | 1 | Sticky flag for illegal level programming |

## Verification
The properties assume the environment keeps each FIFO's occupancy plus its in-flight count within the FIFO depth. They also assume a return pulse arrives only for an entry that was actually granted, and that an acknowledge matters only while a request is pending. The bench models each FIFO itself. Occupancy rises only by one entry per return pulse, and only while the bench's model shows entries in flight. Occupancy falls only by consumer drain. Acknowledges are driven only while the model shows a pending request. The drain and return rates are varied across phases so that both hysteresis thresholds are crossed in both directions.

// File: rtl/fetch_req_pkg.sv
package fetch_req_pkg;
  typedef enum logic {SRC_GFX = 1'b0, SRC_VID = 1'b1} fetch_src_e;
  typedef enum logic {BURST_32B = 1'b0, BURST_64B = 1'b1} burst_e;
  localparam int unsigned LINE_ENT = 4;  // 64-bit entries per 32-byte line
  localparam int unsigned LVL_UNIT = 4;  // entries per level step
endpackage

// File: rtl/fifo_space_mon.sv
module fifo_space_mon #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] occ_i,
  input  logic          ret_i,
  input  logic          grant_i,
  input  logic [3:0]    grant_ent_i,
  input  logic [3:0]    thr_i,
  output logic          need_o
);
  localparam int unsigned SW = CW + 2;

  logic [CW-1:0] inflight_q;
  logic [SW-1:0] inflight_nxt;
  logic [SW-1:0] used_plus_thr;

  always_comb begin
    inflight_nxt = SW'(inflight_q) + (grant_i ? SW'(grant_ent_i) : '0) - SW'(ret_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) inflight_q <= '0;
    else         inflight_q <= inflight_nxt[CW-1:0];
  end

  // granted-but-unreturned entries count as occupied
  assign used_plus_thr = SW'(occ_i) + SW'(inflight_q) + SW'(thr_i);
  assign need_o        = (used_plus_thr <= SW'(DEPTH));
endmodule

// File: rtl/hp_hyst.sv
module hp_hyst
  import fetch_req_pkg::*;
#(
  parameter int unsigned LVL_W = 4,
  parameter int unsigned CW    = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             hold_i,
  input  logic [CW-1:0]    occ_i,
  input  logic [LVL_W-1:0] start_i,
  input  logic [LVL_W-1:0] end_i,
  output logic             hp_o,
  output logic             err_o
);
  localparam int unsigned SH = $clog2(LVL_UNIT);
  localparam int unsigned TW = (LVL_W + SH > CW) ? LVL_W + SH : CW;

  logic [TW-1:0] occ_w, start_w, end_w;
  logic          lvl_bad;
  logic          hp_q, hp_d, err_q;

  assign occ_w   = TW'(occ_i);
  assign start_w = TW'(start_i) << SH;
  assign end_w   = TW'(end_i) << SH;
  assign lvl_bad = (start_i == '0) || (end_i == '0) || (start_i >= end_i);

  always_comb begin
    hp_d = hp_q;
    if (lvl_bad)         hp_d = 1'b0;
    else if (!en_i)      hp_d = hold_i ? hp_q : 1'b0;
    else if (hp_q)       hp_d = (occ_w < end_w);
    else                 hp_d = (occ_w <= start_w);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hp_q  <= 1'b0;
      err_q <= 1'b0;
    end else begin
      hp_q  <= hp_d;
      err_q <= err_q | (en_i & lvl_bad);
    end
  end

  assign hp_o  = hp_q;
  assign err_o = err_q;
endmodule

// File: rtl/fetch_req_ctrl.sv
module fetch_req_ctrl
  import fetch_req_pkg::*;
#(
  parameter int unsigned GFX_DEPTH = 64,
  parameter int unsigned VID_DEPTH = 32,
  parameter int unsigned LVL_W     = 4,
  localparam int unsigned GCW      = $clog2(GFX_DEPTH + 1),
  localparam int unsigned VCW      = $clog2(VID_DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             vid_64b_i,
  input  logic [LVL_W-1:0] hp_start_i,
  input  logic [LVL_W-1:0] hp_end_i,
  input  logic [GCW-1:0]   gfx_occ_i,
  input  logic [VCW-1:0]   vid_occ_i,
  input  logic             gfx_ret_i,
  input  logic             vid_ret_i,
  input  logic             req_ack_i,
  output logic             req_valid_o,
  output logic             req_src_o,
  output logic             req_burst_o,
  output logic             req_hipri_o,
  output logic             cfg_err_o
);
  localparam logic [3:0] ONE_LINE = 4'(LINE_ENT);
  localparam logic [3:0] TWO_LINE = 4'(2 * LINE_ENT);

  logic       valid_q;
  fetch_src_e src_q;
  burst_e     burst_q;
  logic       grant, gfx_need, vid_need;
  logic [3:0] vid_thr, vid_ent;

  assign grant   = valid_q & req_ack_i;
  assign vid_thr = vid_64b_i ? TWO_LINE : ONE_LINE;
  assign vid_ent = (burst_q == BURST_64B) ? TWO_LINE : ONE_LINE;

  fifo_space_mon #(.DEPTH(GFX_DEPTH), .CW(GCW)) u_gfx_mon (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .occ_i       (gfx_occ_i),
    .ret_i       (gfx_ret_i),
    .grant_i     (grant && (src_q == SRC_GFX)),
    .grant_ent_i (ONE_LINE),
    .thr_i       (ONE_LINE),
    .need_o      (gfx_need)
  );

  fifo_space_mon #(.DEPTH(VID_DEPTH), .CW(VCW)) u_vid_mon (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .occ_i       (vid_occ_i),
    .ret_i       (vid_ret_i),
    .grant_i     (grant && (src_q == SRC_VID)),
    .grant_ent_i (vid_ent),
    .thr_i       (vid_thr),
    .need_o      (vid_need)
  );

  hp_hyst #(.LVL_W(LVL_W), .CW(GCW)) u_hyst (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .hold_i  (valid_q),
    .occ_i   (gfx_occ_i),
    .start_i (hp_start_i),
    .end_i   (hp_end_i),
    .hp_o    (req_hipri_o),
    .err_o   (cfg_err_o)
  );

  // single request slot; display wins over video
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      src_q   <= SRC_GFX;
      burst_q <= BURST_32B;
    end else if (valid_q) begin
      if (req_ack_i) valid_q <= 1'b0;
    end else if (en_i && (gfx_need || vid_need)) begin
      valid_q <= 1'b1;
      src_q   <= gfx_need ? SRC_GFX : SRC_VID;
      burst_q <= (!gfx_need && vid_64b_i) ? BURST_64B : BURST_32B;
    end
  end

  assign req_valid_o = valid_q;
  assign req_src_o   = src_q;
  assign req_burst_o = burst_q;
endmodule

// File: rtl/fetch_req_ctrl_chk.sv
module fetch_req_ctrl_chk #(
  parameter int unsigned LVL_W = 4,
  parameter int unsigned GCW   = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic [LVL_W-1:0] hp_start_i,
  input logic [LVL_W-1:0] hp_end_i,
  input logic [GCW-1:0]   gfx_occ_i,
  input logic             req_ack_i,
  input logic             req_valid_o,
  input logic             req_src_o,
  input logic             req_burst_o,
  input logic             req_hipri_o,
  input logic             cfg_err_o
);
  logic bad;
  int unsigned occ_n, st_n, en_n;
  assign bad   = (hp_start_i == '0) || (hp_end_i == '0) || (hp_start_i >= hp_end_i);
  assign occ_n = int'(gfx_occ_i);
  assign st_n  = int'(hp_start_i) * 4;
  assign en_n  = int'(hp_end_i) * 4;

  p_gfx_burst_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && !req_src_o |-> !req_burst_o);
  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && !req_ack_i |=> req_valid_o && $stable(req_src_o) && $stable(req_burst_o));
  p_drop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && req_ack_i |=> !req_valid_o);
  p_hp_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !bad && occ_n <= st_n |=> req_hipri_o);
  p_hp_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !bad && occ_n >= en_n |=> !req_hipri_o);
  p_hp_bad_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad |=> !req_hipri_o);
  p_err_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && bad |=> cfg_err_o);
  p_err_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |=> cfg_err_o);
  p_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i && !req_valid_o |=> !req_valid_o && !req_hipri_o);
endmodule

bind fetch_req_ctrl fetch_req_ctrl_chk #(.LVL_W(LVL_W), .GCW(GCW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_i        (en_i),
  .hp_start_i  (hp_start_i),
  .hp_end_i    (hp_end_i),
  .gfx_occ_i   (gfx_occ_i),
  .req_ack_i   (req_ack_i),
  .req_valid_o (req_valid_o),
  .req_src_o   (req_src_o),
  .req_burst_o (req_burst_o),
  .req_hipri_o (req_hipri_o),
  .cfg_err_o   (cfg_err_o)
);

// File: tb/fetch_req_ctrl_bench.sv
module fetch_req_ctrl_bench;
  localparam int GD = 64;
  localparam int VD = 32;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b0, vid_64b_i = 1'b0;
  logic [3:0] hp_start_i = 4'd4, hp_end_i = 4'd12;
  logic [6:0] gfx_occ_i = '0;
  logic [5:0] vid_occ_i = '0;
  logic       gfx_ret_i = 1'b0, vid_ret_i = 1'b0, req_ack_i = 1'b0;
  logic       req_valid_o, req_src_o, req_burst_o, req_hipri_o, cfg_err_o;

  always #10 clk = ~clk;

  fetch_req_ctrl u_fetch_req_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i), .vid_64b_i(vid_64b_i),
    .hp_start_i(hp_start_i), .hp_end_i(hp_end_i),
    .gfx_occ_i(gfx_occ_i), .vid_occ_i(vid_occ_i),
    .gfx_ret_i(gfx_ret_i), .vid_ret_i(vid_ret_i), .req_ack_i(req_ack_i),
    .req_valid_o(req_valid_o), .req_src_o(req_src_o), .req_burst_o(req_burst_o),
    .req_hipri_o(req_hipri_o), .cfg_err_o(cfg_err_o)
  );

  int checks = 0, errors = 0;
  string phase = "R11";

  // reference model state
  int m_valid, m_src, m_burst, m_hp, m_err, m_gin, m_vin;
  // environment
  int g_occ = 0, v_occ = 0;
  int gdrain = 0, vdrain = 0, ack_pct = 100, gret_pct = 100, vret_pct = 100;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_valid = 0; m_src = 0; m_burst = 0; m_hp = 0; m_err = 0; m_gin = 0; m_vin = 0;
    end else begin
      int gfree, vfree, vthr, bad, n_hp, ack;
      int st, en;
      st = int'(hp_start_i); en = int'(hp_end_i);
      ack = int'(req_ack_i);
      gfree = GD - int'(gfx_occ_i) - m_gin;
      vfree = VD - int'(vid_occ_i) - m_vin;
      vthr  = vid_64b_i ? 8 : 4;
      bad   = (st == 0 || en == 0 || st >= en) ? 1 : 0;
      if (bad != 0)      n_hp = 0;
      else if (!en_i)    n_hp = (m_valid != 0) ? m_hp : 0;
      else if (m_hp != 0) n_hp = (int'(gfx_occ_i) >= en * 4) ? 0 : 1;
      else               n_hp = (int'(gfx_occ_i) <= st * 4) ? 1 : 0;
      if (en_i && bad != 0) m_err = 1;
      if (m_valid != 0 && ack != 0) begin
        if (m_src == 0) m_gin += 4;
        else            m_vin += (m_burst != 0) ? 8 : 4;
      end
      if (gfx_ret_i) m_gin -= 1;
      if (vid_ret_i) m_vin -= 1;
      if (m_valid != 0) begin
        if (ack != 0) m_valid = 0;
      end else if (en_i) begin
        if (gfree >= 4) begin
          m_valid = 1; m_src = 0; m_burst = 0;
        end else if (vfree >= vthr) begin
          m_valid = 1; m_src = 1; m_burst = vid_64b_i ? 1 : 0;
        end
      end
      m_hp = n_hp;
    end
  end

  task automatic chk(input string name, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", phase, name, act, exp);
    end
  endtask

  task automatic compare();
    chk("req_valid_o", int'(req_valid_o), m_valid);
    if (m_valid != 0) begin
      chk("req_src_o", int'(req_src_o), m_src);
      chk("req_burst_o", int'(req_burst_o), m_burst);
    end
    chk("req_hipri_o", int'(req_hipri_o), m_hp);
    chk("cfg_err_o", int'(cfg_err_o), m_err);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare();
      req_ack_i = (m_valid != 0) && ($urandom_range(99) < ack_pct);
      gfx_ret_i = (m_gin > 0) && ($urandom_range(99) < gret_pct);
      vid_ret_i = (m_vin > 0) && ($urandom_range(99) < vret_pct);
      if (gfx_ret_i) g_occ++;
      if (vid_ret_i) v_occ++;
      if (g_occ > 0 && $urandom_range(99) < gdrain) g_occ--;
      if (v_occ > 0 && $urandom_range(99) < vdrain) v_occ--;
      gfx_occ_i = 7'(g_occ);
      vid_occ_i = 6'(v_occ);
    end
  endtask

  initial begin
    #(64'd200000 * 20);
    errors++; checks++;
    $display("FAIL watchdog expired in phase %s", phase);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R11: reset state
    run(3);
    rst_ni = 1'b1;
    phase = "R11"; run(2);
    // R1: display refill, video full
    g_occ = 40; v_occ = 32; en_i = 1'b1;
    phase = "R1"; run(60);
    // R2: video single-line trigger
    phase = "R2"; vid_64b_i = 1'b0; vdrain = 60; run(80);
    // R3: video two-line trigger, 64-byte bursts
    phase = "R3"; vid_64b_i = 1'b1; vdrain = 40; run(120);
    // R4: both FIFOs draining
    phase = "R4"; gdrain = 50; vdrain = 50; run(150);
    // R5: slow acknowledge
    phase = "R5"; ack_pct = 15; run(150);
    // R6: slow data return
    phase = "R6"; ack_pct = 100; gret_pct = 10; vret_pct = 10; run(200);
    gret_pct = 100; vret_pct = 100;
    // R7/R8: drive display occupancy across both levels repeatedly
    for (int k = 0; k < 4; k++) begin
      phase = "R7"; gdrain = 95; run(80);
      phase = "R8"; gdrain = 0;  run(80);
    end
    // R9: illegal levels, then legal again with sticky error
    phase = "R9"; gdrain = 95; hp_start_i = 4'd6; hp_end_i = 4'd6; run(60);
    hp_start_i = 4'd0; run(20);
    hp_start_i = 4'd4; hp_end_i = 4'd12; run(60);
    // R10: disable while a request is pending, ack withheld then given
    phase = "R10"; ack_pct = 0; gdrain = 90; run(20);
    en_i = 1'b0; run(15);
    ack_pct = 100; run(40);
    en_i = 1'b1; run(20);
    // mixed traffic
    phase = "R4";
    for (int k = 0; k < 40; k++) begin
      gdrain    = int'($urandom_range(100));
      vdrain    = int'($urandom_range(100));
      ack_pct   = 10 + int'($urandom_range(90));
      gret_pct  = 20 + int'($urandom_range(80));
      vret_pct  = 20 + int'($urandom_range(80));
      vid_64b_i = 1'($urandom_range(1));
      en_i      = ($urandom_range(9) != 0);
      hp_start_i = 4'(1 + $urandom_range(6));
      hp_end_i   = 4'(8 + $urandom_range(7));
      run(60);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule